// File: doc/BRIEF.md
# Variable-Length Serial Flash Transfer Engine

The block is a register-programmed SPI master for talking to a serial flash. Software places a 64-bit transmit word in two 32-bit data registers, chooses a length of one to eight bytes, and starts the transfer by writing the upper data word. The engine then shifts the selected number of bytes out on MOSI, starting from bit 63, while it collects the reply from MISO. Only the most recent 32 received bits are kept, right-aligned, in the lower data register. A busy flag in the control register stays set for the whole transfer.

The control register selects the SPI mode (clock polarity and phase), a 3-bit clock prescaler, and a high-speed mode that runs SCK at half the system clock. A separate enable bit gates the chip-select. With that bit clear, a transfer produces clock pulses while the flash stays deselected, which is how a flash can be given its wake-up dummy clocks (an 8-byte transfer gives 64 of them). Writing a control word with the enable bit clear, and a word of zero in particular, stops any transfer in progress.

Top module: `flash_xfer_engine`

## Requirements
- R1: After reset the control register reads 0, cs_n is 1 and sck is 0.
- R2: Address 0 is the control register: bit 0 enable, bits 3:1 prescaler index, bit 4 clock polarity, bit 5 clock phase, bits 9:6 length in bytes, bit 10 chip-select enable, bit 11 high-speed mode, bit 31 busy (read-only). Bits 11:0 read back as written. Address 1 takes the low transmit word on write and returns the receive word on read. Address 2 takes the high transmit word on write.
- R3: A write to address 2 starts a transfer when enable is 1, the engine is idle and the length is 1 to 8; busy reads 1 from the next cycle on. With a length of 0 or above 8, or with enable 0, nothing starts and sck does not toggle.
- R4: MOSI carries the top 8*length bits of {high word, low word}, bit 63 first.
- R5: After a transfer, address 1 reads the last 32 bits sampled from MISO, the most recent bit in bit 0. Bits that were not received read 0.
- R6: sck idles at the polarity bit. A transfer makes exactly 16*length sck edges. With phase 0, MISO is sampled on the odd-numbered edges (1st, 3rd, ...) and MOSI changes on the even-numbered ones. With phase 1, MOSI changes on the odd-numbered edges and MISO is sampled on the even-numbered ones.
- R7: Successive sck edges are 2, 4, 8, 64, 128, 1024, 2048 or 4096 clock cycles apart for prescaler index 0 to 7. In high-speed mode they are 1 cycle apart whatever the prescaler.
- R8: cs_n is 0 only during a transfer whose chip-select enable is 1. Busy clears, and cs_n returns to 1, one edge interval after the last sck edge.
- R9: A control write with bit 0 at 0 ends any transfer. From the next cycle, busy is 0 and cs_n is 1.
- R10: A write to address 2 while busy neither restarts nor alters the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Active-low chip-select |

## Verification
The assertions assume that MISO is already synchronous to clk and stays stable on the clock edge where the engine samples it. The bench's flash model meets this by changing MISO only right after the sck edges on which MOSI changes. The idle-clock property assumes that the polarity bit is not rewritten in the cycle that matters, so the bench writes the control register only while the engine is idle and waits two cycles before it starts counting edges. The property that a start follows a write to the high word relies on the bench never issuing two register accesses in one cycle.

// File: rtl/flash_xfer_pkg.sv
`timescale 1ns/1ps
package flash_xfer_pkg;
  localparam int BUS_W     = 32;
  localparam int TX_W      = 64;
  localparam int RX_W      = 32;
  localparam int LEN_W     = 4;
  localparam int PSC_W     = 3;
  localparam int DIV_W     = 12;
  localparam int MAX_BYTES = TX_W / 8;
  localparam int CFG_W     = 12;
  localparam int BUSY_BIT  = 31;

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_LO  = 2'd1;
  localparam logic [1:0] A_HI  = 2'd2;

  // control fields, LSB last: en=0, psc=3:1, cpol=4, cpha=5, len=9:6, cs_en=10, hs=11
  typedef struct packed {
    logic             hs;
    logic             cs_en;
    logic [LEN_W-1:0] len;
    logic             cpha;
    logic             cpol;
    logic [PSC_W-1:0] psc;
    logic             en;
  } cfg_t;

  // terminal count of the edge timer: the divider minus one
  function automatic logic [DIV_W-1:0] psc_limit(input logic [PSC_W-1:0] sel);
    int e;
    if (sel < 3)      e = int'(sel) + 1;
    else if (sel < 5) e = int'(sel) + 3;
    else              e = int'(sel) + 5;
    return DIV_W'((1 << e) - 1);
  endfunction
endpackage

// File: rtl/flash_xfer_tick.sv
`timescale 1ns/1ps
module flash_xfer_tick
  import flash_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hs,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n, lim;
  logic             at_lim;

  always_comb begin
    lim    = hs ? '0 : psc_limit(psc);
    at_lim = (cnt_q >= lim);
    tick   = run && at_lim;
    if (!run || at_lim) cnt_n = '0;
    else                cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/flash_xfer_shift.sv
`timescale 1ns/1ps
module flash_xfer_shift
  import flash_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LEN_W-1:0] len,
  input  logic [TX_W-1:0]  tx_word,
  input  logic             miso,
  output logic             active,
  output logic             sck,
  output logic             mosi,
  output logic [RX_W-1:0]  rx_word
);
  localparam int EDGE_W = LEN_W + 4;

  logic              act_q, act_n, sck_q, sck_n, mosi_q, mosi_n;
  logic [TX_W-1:0]   sr_q, sr_n;
  logic [RX_W-1:0]   rx_q, rx_n;
  logic [EDGE_W-1:0] edge_q, edge_n, total;
  logic              sample_edge;

  always_comb begin
    act_n       = act_q;
    sck_n       = sck_q;
    mosi_n      = mosi_q;
    sr_n        = sr_q;
    rx_n        = rx_q;
    edge_n      = edge_q;
    total       = {len, 4'b0000};
    sample_edge = (~edge_q[0]) ^ cpha;
    if (abort) begin
      act_n = 1'b0;
      sck_n = cpol;
    end else if (start) begin
      act_n  = 1'b1;
      sck_n  = cpol;
      edge_n = '0;
      rx_n   = '0;
      if (!cpha) begin
        mosi_n = tx_word[TX_W-1];
        sr_n   = tx_word << 1;
      end else begin
        mosi_n = 1'b0;
        sr_n   = tx_word;
      end
    end else if (!act_q) begin
      sck_n = cpol;
    end else if (tick) begin
      if (edge_q == total) begin
        act_n = 1'b0;
      end else begin
        sck_n  = ~sck_q;
        edge_n = edge_q + 1'b1;
        if (sample_edge) begin
          rx_n = {rx_q[RX_W-2:0], miso};
        end else begin
          mosi_n = sr_q[TX_W-1];
          sr_n   = sr_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      sr_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
    end else begin
      act_q  <= act_n;
      sck_q  <= sck_n;
      mosi_q <= mosi_n;
      sr_q   <= sr_n;
      rx_q   <= rx_n;
      edge_q <= edge_n;
    end
  end

  assign active  = act_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/flash_xfer_engine.sv
`timescale 1ns/1ps
module flash_xfer_engine
  import flash_xfer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  cfg_t             cfg_q, cfg_n;
  logic [BUS_W-1:0] lo_q, lo_n;
  logic             xfer_active, start_go, abort_go, tick, len_ok;
  logic [RX_W-1:0]  rx_word;
  logic             cfg_en, cfg_cpol, cfg_cs_en;
  logic [LEN_W-1:0] cfg_len;

  assign cfg_en    = cfg_q.en;
  assign cfg_cpol  = cfg_q.cpol;
  assign cfg_cs_en = cfg_q.cs_en;
  assign cfg_len   = cfg_q.len;

  always_comb begin
    cfg_n    = cfg_q;
    lo_n     = lo_q;
    len_ok   = (cfg_q.len != '0) && (int'(cfg_q.len) <= MAX_BYTES);
    start_go = wr_en && (addr == A_HI) && cfg_q.en && !xfer_active && len_ok;
    abort_go = wr_en && (addr == A_CTL) && !wdata[0];
    if (wr_en && addr == A_CTL) cfg_n = cfg_t'(wdata[CFG_W-1:0]);
    if (wr_en && addr == A_LO)  lo_n  = wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cfg_q <= '0;
      lo_q  <= '0;
    end else begin
      cfg_q <= cfg_n;
      lo_q  <= lo_n;
    end
  end

  flash_xfer_tick u_tick (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (xfer_active),
    .hs    (cfg_q.hs),
    .psc   (cfg_q.psc),
    .tick  (tick)
  );

  flash_xfer_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start   (start_go),
    .abort   (abort_go),
    .tick    (tick),
    .cpol    (cfg_q.cpol),
    .cpha    (cfg_q.cpha),
    .len     (cfg_q.len),
    .tx_word ({wdata, lo_q}),
    .miso    (miso),
    .active  (xfer_active),
    .sck     (sck),
    .mosi    (mosi),
    .rx_word (rx_word)
  );

  assign cs_n = ~(xfer_active & cfg_q.cs_en);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL: begin
        rdata[CFG_W-1:0] = cfg_q;
        rdata[BUSY_BIT]  = xfer_active;
      end
      A_LO:    rdata[RX_W-1:0] = rx_word;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_xfer_chk.sv
`timescale 1ns/1ps
module flash_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic        wbit0,
  input logic        busy,
  input logic        sck,
  input logic        cs_n,
  input logic        cfg_en,
  input logic        cfg_cpol,
  input logic        cfg_cs_en,
  input logic [3:0]  cfg_len
);
  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && cfg_en && !busy && cfg_len != 4'd0 && cfg_len <= 4'd8) |=> busy);

  // R3
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !busy && (cfg_len == 4'd0 || cfg_len > 4'd8)) |=> !busy);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !wbit0) |=> (!busy && cs_n));

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cfg_cpol)) |-> (sck == cfg_cpol));

  // R8
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (cfg_cs_en && busy));
endmodule

bind flash_xfer_engine flash_xfer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .wr_en     (wr_en),
  .addr      (addr),
  .wbit0     (wdata[0]),
  .busy      (xfer_active),
  .sck       (sck),
  .cs_n      (cs_n),
  .cfg_en    (cfg_en),
  .cfg_cpol  (cfg_cpol),
  .cfg_cs_en (cfg_cs_en),
  .cfg_len   (cfg_len)
);

// File: tb/sim_flash_xfer_engine.sv
`timescale 1ns/1ps
module sim_flash_xfer_engine;
  logic        clk, rst_n, wr_en, miso;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        sck, mosi, cs_n;

  int total, bad;
  int cyc;

  // flash model state
  bit          slave_on;
  bit          s_cpol, s_cpha;
  logic [63:0] s_reply, s_cap;
  int          s_idx, s_edges, s_last, s_min, s_max;
  bit          s_cs_seen;

  flash_xfer_engine u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (slave_on && !cs_n) s_cs_seen = 1'b1;
  end

  always @(sck) begin
    if (slave_on) begin
      if (s_edges > 0) begin
        if (cyc - s_last < s_min) s_min = cyc - s_last;
        if (cyc - s_last > s_max) s_max = cyc - s_last;
      end
      s_last = cyc;
      if ((sck != s_cpol) ^ s_cpha) begin
        s_cap = {s_cap[62:0], mosi};
      end else begin
        if (s_idx >= 0) miso = s_reply[s_idx];
        s_idx--;
      end
      s_edges++;
    end
  end

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_up();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] mk(input bit en, input int psc, input bit cpol,
                                     input bit cpha, input int len, input bit csen, input bit hs);
    return {20'b0, hs, csen, 4'(len), cpha, cpol, 3'(psc), en};
  endfunction

  function automatic int half_of(input int psc, input bit hs);
    int t[8] = '{2, 4, 8, 64, 128, 1024, 2048, 4096};
    return hs ? 1 : t[psc];
  endfunction

  task automatic arm_slave(input bit cpol, input bit cpha, input logic [63:0] reply);
    s_cpol = cpol; s_cpha = cpha; s_reply = reply;
    s_cap = '0; s_edges = 0; s_min = 1 << 30; s_max = 0; s_cs_seen = 1'b0;
    if (!cpha) begin miso = reply[63]; s_idx = 62; end
    else       begin miso = 1'b0;      s_idx = 63; end
    slave_on = 1'b1;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      rd(2'd0, d);
      if (!d[31]) break;
    end
  endtask

  task automatic run_xfer(input string tag, input int len, input bit cpol, input bit cpha,
                          input int psc, input bit hs, input bit csen,
                          input logic [63:0] tx, input logic [63:0] reply, input bit poke);
    logic [31:0] d;
    int n;
    n = 8 * len;
    wr(2'd0, mk(1'b1, psc, cpol, cpha, len, csen, hs));
    repeat (2) @(negedge clk);
    arm_slave(cpol, cpha, reply);
    wr(2'd1, tx[31:0]);
    wr(2'd2, tx[63:32]);
    rd(2'd0, d);
    chk({tag, " R3 busy after start"}, 64'(d[31]), 64'd1);
    if (poke) begin
      repeat (4) @(negedge clk);
      wr(2'd2, ~tx[63:32]);
      wr(2'd1, ~tx[31:0]);
    end
    wait_idle();
    @(negedge clk);
    slave_on = 1'b0;
    chk({tag, " R6 edge count"}, 64'(s_edges), 64'(2 * n));
    chk({tag, " R4 mosi bits"}, s_cap, tx >> (64 - n));
    rd(2'd1, d);
    chk({tag, " R5 rx word"}, 64'(d), 64'((reply >> (64 - n)) & 64'hFFFF_FFFF));
    chk({tag, " R8 cs activity"}, 64'(s_cs_seen), 64'(csen));
    chk({tag, " R8 cs_n idle"}, 64'(cs_n), 64'd1);
    chk({tag, " R7 min edge gap"}, 64'(s_min), 64'(half_of(psc, hs)));
    chk({tag, " R7 max edge gap"}, 64'(s_max), 64'(half_of(psc, hs)));
    chk({tag, " R6 sck idle level"}, 64'(sck), 64'(cpol));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(2'd0, d);
    chk("R1 ctrl after reset", 64'(d), 64'd0);
    chk("R1 cs_n after reset", 64'(cs_n), 64'd1);
    chk("R1 sck after reset", 64'(sck), 64'd0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(2'd0, 32'h0000_0ABC);
    @(negedge clk);
    rd(2'd0, d);
    chk("R2 ctrl readback", 64'(d), 64'h0000_0ABC);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_no_start(input string tag, input bit en, input int len);
    logic [31:0] d;
    wr(2'd0, mk(en, 0, 1'b0, 1'b0, len, 1'b1, 1'b1));
    repeat (2) @(negedge clk);
    arm_slave(1'b0, 1'b0, 64'h0);
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'h9ABC_DEF0);
    rd(2'd0, d);
    chk({tag, " R3 busy stays low"}, 64'(d[31]), 64'd0);
    repeat (20) @(negedge clk);
    chk({tag, " R3 no sck edges"}, 64'(s_edges), 64'd0);
    chk({tag, " R3 cs_n stays high"}, 64'(s_cs_seen), 64'd0);
    slave_on = 1'b0;
  endtask

  task automatic t_abort();
    logic [31:0] d;
    wr(2'd0, mk(1'b1, 2, 1'b1, 1'b0, 8, 1'b1, 1'b0));
    wr(2'd1, 32'hFFFF_0000);
    wr(2'd2, 32'h0000_FFFF);
    repeat (20) @(negedge clk);
    rd(2'd0, d);
    chk("R9 busy before abort", 64'(d[31]), 64'd1);
    chk("R9 cs_n low before abort", 64'(cs_n), 64'd0);
    wr(2'd0, 32'h0);
    rd(2'd0, d);
    chk("R9 ctrl after abort", 64'(d), 64'd0);
    chk("R9 cs_n after abort", 64'(cs_n), 64'd1);
    @(negedge clk);
    chk("R9 sck back to idle", 64'(sck), 64'd0);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; slave_on = 1'b0;
    wr_en = 1'b0; addr = 2'd0; wdata = '0; miso = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_readback();
    run_xfer("mode0 8B",   8, 1'b0, 1'b0, 0, 1'b0, 1'b1,
             64'hA5C3_0F1E_7788_9966, 64'h1357_9BDF_2468_ACE0, 1'b0);
    run_xfer("mode3 3B",   3, 1'b1, 1'b1, 1, 1'b0, 1'b1,
             64'hC0DE_F00D_0000_0000, 64'hF0E1_D2C3_B4A5_9687, 1'b0);
    run_xfer("mode1 hs 1B", 1, 1'b0, 1'b1, 7, 1'b1, 1'b1,
             64'h8100_0000_0000_0000, 64'h6900_0000_0000_0000, 1'b0);
    run_xfer("mode2 5B",   5, 1'b1, 1'b0, 3, 1'b0, 1'b1,
             64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_CAFE_5A5A, 1'b0);
    run_xfer("dummy 8B",   8, 1'b0, 1'b0, 0, 1'b0, 1'b0,
             64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    run_xfer("R10 rewrite busy", 4, 1'b0, 1'b0, 0, 1'b0, 1'b1,
             64'h5AA5_3CC3_0000_0000, 64'h0F0F_F0F0_0000_0000, 1'b1);
    run_xfer("psc4 1B",    1, 1'b0, 1'b0, 4, 1'b0, 1'b1,
             64'h3C00_0000_0000_0000, 64'hC300_0000_0000_0000, 1'b0);
    run_xfer("psc7 1B",    1, 1'b1, 1'b0, 7, 1'b0, 1'b1,
             64'hE700_0000_0000_0000, 64'h1800_0000_0000_0000, 1'b0);
    t_no_start("len0", 1'b1, 0);
    t_no_start("len9", 1'b1, 9);
    t_no_start("disabled", 1'b0, 4);
    t_abort();
    finish_up();
  end
endmodule